// File: doc/BRIEF.md
# Four-Function ALU with Condition Codes

This block is a purely combinational arithmetic logic unit. It accepts two operand words and a two-bit function code. It returns the result word together with three condition values: signed overflow, zero and carry/borrow. The function code picks one of addition, subtraction, bitwise AND or bitwise XOR.

All three condition values are produced in parallel with the result for every function. They are meant to be captured by a separate condition-code register, which is not part of this block. Nothing in the block is clocked. A change on any input reaches the outputs after propagation delay only.

The word width is a parameter with a default of 32 bits. The sign and carry logic always works from the top bit of the chosen width.

Top module: `cc_alu`

## Requirements
- R1: The block has no clock or state; result and flags follow an input change without any clock edge.
- R2: Function code 2'd0 gives result = (X + Y) modulo 2^WIDTH.
- R3: Function code 2'd1 gives result = (X - Y) modulo 2^WIDTH.
- R4: Function code 2'd2 gives result = X AND Y, bit by bit.
- R5: Function code 2'd3 gives result = X XOR Y, bit by bit.
- R6: The zero flag is 1 exactly when every bit of the result is 0, for all four function codes.
- R7: For code 2'd0, the overflow flag is 1 exactly when X and Y have the same top bit and the result's top bit differs from it.
- R8: For code 2'd1, the overflow flag is 1 exactly when X and Y have different top bits and the result's top bit differs from X's.
- R9: For code 2'd0, the carry flag is the carry out of the top bit of the unsigned sum.
- R10: For code 2'd1, the carry flag is the borrow, which is 1 exactly when X < Y as unsigned numbers.
- R11: For codes 2'd2 and 2'd3, the overflow and carry flags are both 0.
- R12: WIDTH sets the word size (default 32). All flags use bit WIDTH-1 as the top bit, so an 8-bit instance wraps and overflows at 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_sel | input | 2 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| opnd_x | input | WIDTH | First operand |
| opnd_y | input | WIDTH | Second operand |
| result | output | WIDTH | Result of the selected function |
| ovf_flag | output | 1 | Two's-complement overflow |
| zero_flag | output | 1 | Result is all zeros |
| carry_flag | output | 1 | Carry out for add, borrow for subtract |

## Verification
Addition and subtraction are driven across the signed and unsigned boundary pairs, so that overflow and carry can be told apart:
- maximum positive plus one sets overflow without carry;
- all-ones plus one sets carry and zero without overflow;
- the two most-negative words added set both overflow and carry;
- zero minus one borrows without overflow;
- most-negative minus one overflows without a borrow.

Equal operands under subtract and XOR separate the zero flag from the other flags. Complementary words under AND do the same.

Random operands under every code, and a mid-cycle input change with no clock edge, check the general function and the absence of state. A second instance at 8 bits confirms that wrapping and the sign position follow the width parameter.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  // one-bit full-adder sum
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // one-bit full-adder carry (generate / propagate form)
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a ^ b));
  endfunction

  // signed overflow judged only from operand and result signs
  function automatic logic sign_overflow(input logic is_sub, input logic sx,
                                         input logic sy, input logic sr);
    if (is_sub) return (sx != sy) && (sr != sx);
    else        return (sx == sy) && (sr != sx);
  endfunction

endpackage

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             do_sub,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_top_in,
  output logic             carry_top_out,
  output logic             ovf_out,
  output logic             cb_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] y_eff;
  logic [WIDTH:0]   chain;

  assign y_eff    = do_sub ? ~y_in : y_in;
  assign chain[0] = do_sub;

  // ripple chain, one stage per bit, so the carry into the top bit is visible
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_out[i]   = fa_sum(x_in[i], y_eff[i], chain[i]);
    assign chain[i+1]   = fa_carry(x_in[i], y_eff[i], chain[i]);
  end

  assign carry_top_in  = chain[MSB];
  assign carry_top_out = chain[WIDTH];

  // overflow from the carry pair; borrow is the inverted carry on subtract
  assign ovf_out = carry_top_in ^ carry_top_out;
  assign cb_out  = do_sub ? ~carry_top_out : carry_top_out;

  // assertions: compare the carry-based flags with sign / magnitude rules
  always_comb begin
    a_r7_r8_sign_rule: assert (ovf_out ==
        sign_overflow(do_sub, x_in[MSB], y_in[MSB], sum_out[MSB]))
      else $error("overflow disagrees with sign rule");
    if (do_sub) begin
      a_r10_borrow: assert (cb_out == (x_in < y_in))
        else $error("borrow disagrees with unsigned compare");
      a_r3_diff: assert (sum_out + y_in == x_in)
        else $error("difference plus y is not x");
    end else begin
      a_r9_carry: assert (cb_out == ({1'b0, x_in} + {1'b0, y_in} > {1'b0, {WIDTH{1'b1}}}))
        else $error("carry disagrees with wide sum");
    end
  end

endmodule

// File: rtl/cc_alu_logic.sv
module cc_alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  output logic [WIDTH-1:0] and_out,
  output logic [WIDTH-1:0] xor_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_out[i] = x_in[i] & y_in[i];
    assign xor_out[i] = x_in[i] ^ y_in[i];
  end

  always_comb begin
    // a bit cannot be both in the AND and the XOR of the same pair
    a_r4_r5_disjoint: assert ((and_out & xor_out) == '0)
      else $error("AND and XOR words overlap");
  end

endmodule

// File: rtl/cc_alu_zero.sv
module cc_alu_zero #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_in,
  output logic             is_zero
);
  logic [WIDTH-1:0] any_set;

  // running OR from bit 0 upward
  assign any_set[0] = word_in[0];
  for (genvar i = 1; i < WIDTH; i++) begin : g_or
    assign any_set[i] = any_set[i-1] | word_in[i];
  end

  assign is_zero = ~any_set[WIDTH-1];

endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       fn_sel,
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  output logic [WIDTH-1:0] result,
  output logic             ovf_flag,
  output logic             zero_flag,
  output logic             carry_flag
);
  alu_fn_e          fn;
  logic             arith_sel;
  logic [WIDTH-1:0] arith_word;
  logic             arith_c_in_msb;
  logic             arith_c_out;
  logic             arith_ovf;
  logic             arith_cb;
  logic [WIDTH-1:0] and_word;
  logic [WIDTH-1:0] xor_word;

  assign fn        = alu_fn_e'(fn_sel);
  assign arith_sel = (fn == FN_ADD) || (fn == FN_SUB);

  cc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .do_sub        (fn == FN_SUB),
    .x_in          (opnd_x),
    .y_in          (opnd_y),
    .sum_out       (arith_word),
    .carry_top_in  (arith_c_in_msb),
    .carry_top_out (arith_c_out),
    .ovf_out       (arith_ovf),
    .cb_out        (arith_cb)
  );

  cc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .x_in    (opnd_x),
    .y_in    (opnd_y),
    .and_out (and_word),
    .xor_out (xor_word)
  );

  always_comb begin
    unique case (fn)
      FN_ADD, FN_SUB: result = arith_word;
      FN_AND:         result = and_word;
      default:        result = xor_word;
    endcase
  end

  cc_alu_zero #(.WIDTH(WIDTH)) u_zero (
    .word_in (result),
    .is_zero (zero_flag)
  );

  assign ovf_flag   = arith_sel & arith_ovf;
  assign carry_flag = arith_sel & arith_cb;

  always_comb begin
    a_r6_zero: assert (zero_flag == ($countones(result) == 0))
      else $error("zero flag disagrees with result bit count");
    if (!arith_sel) begin
      a_r11_logic_flags: assert (!ovf_flag && !carry_flag)
        else $error("flags set on a logic function");
    end
    if (fn == FN_ADD) begin
      a_r2_sum: assert (result - opnd_y == opnd_x)
        else $error("sum minus y is not x");
    end
  end

endmodule

// File: tb/cc_alu_bench.sv
module cc_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]   fn_sel;
  logic [W-1:0] opnd_x, opnd_y, result;
  logic         ovf_flag, zero_flag, carry_flag;

  logic [1:0] fn8;
  logic [7:0] x8, y8, r8;
  logic       o8, z8, c8;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  cc_alu #(.WIDTH(W)) u_cc_alu (
    .fn_sel(fn_sel), .opnd_x(opnd_x), .opnd_y(opnd_y),
    .result(result), .ovf_flag(ovf_flag), .zero_flag(zero_flag),
    .carry_flag(carry_flag)
  );

  cc_alu #(.WIDTH(8)) u_cc_alu_w8 (
    .fn_sel(fn8), .opnd_x(x8), .opnd_y(y8),
    .result(r8), .ovf_flag(o8), .zero_flag(z8), .carry_flag(c8)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference using wide integers
  task automatic reference(input int fn, input longint ux, input longint uy,
                           output longint r, output bit o, output bit z, output bit c);
    longint sx, sy, full, sfull;
    longint lim;
    lim = longint'(1) << W;
    sx = (ux >= lim/2) ? ux - lim : ux;
    sy = (uy >= lim/2) ? uy - lim : uy;
    o = 0; c = 0;
    case (fn)
      0: begin full = ux + uy; sfull = sx + sy; r = full % lim;
               c = (full >= lim); o = (sfull >= lim/2) || (sfull < -lim/2); end
      1: begin full = ux - uy; sfull = sx - sy; r = (full + lim) % lim;
               c = (ux < uy); o = (sfull >= lim/2) || (sfull < -lim/2); end
      2: r = ux & uy;
      default: r = ux ^ uy;
    endcase
    z = (r == 0);
  endtask

  task automatic apply(input int fn, input logic [W-1:0] x, input logic [W-1:0] y);
    longint er; bit eo, ez, ec;
    string rt, ot, ct;
    @(posedge clk);
    fn_sel = fn[1:0]; opnd_x = x; opnd_y = y;
    @(negedge clk);
    reference(fn, longint'(x), longint'(y), er, eo, ez, ec);
    case (fn)
      0: begin rt = "R2 add"; ot = "R7 add ovf"; ct = "R9 add carry"; end
      1: begin rt = "R3 sub"; ot = "R8 sub ovf"; ct = "R10 sub borrow"; end
      2: begin rt = "R4 and"; ot = "R11 and ovf"; ct = "R11 and carry"; end
      default: begin rt = "R5 xor"; ot = "R11 xor ovf"; ct = "R11 xor carry"; end
    endcase
    check(rt, longint'(result), er);
    check(ot, longint'(ovf_flag), longint'(eo));
    check(ct, longint'(carry_flag), longint'(ec));
    check("R6 zero", longint'(zero_flag), longint'(ez));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    fn_sel = 0; opnd_x = 0; opnd_y = 0;
    fn8 = 0; x8 = 0; y8 = 0;
    #1;
    // R1: initial outputs follow inputs with no clock edge seen yet
    check("R1 zero at start", longint'(zero_flag), 1);
    check("R1 result at start", longint'(result), 0);

    apply(0, 32'h7FFF_FFFF, 32'h1);
    apply(0, 32'hFFFF_FFFF, 32'h1);
    apply(0, 32'h8000_0000, 32'h8000_0000);
    apply(0, 32'h1234_5678, 32'h0000_1111);
    apply(1, 32'h0, 32'h1);
    apply(1, 32'h8000_0000, 32'h1);
    apply(1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    apply(1, 32'h5, 32'h5);
    apply(2, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    apply(2, 32'hFFFF_FFFF, 32'h8000_0001);
    apply(3, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    apply(3, 32'hAAAA_AAAA, 32'h5555_5555);

    for (int i = 0; i < 400; i++)
      apply(i % 4, $urandom, $urandom);

    // R1: change inputs mid-cycle, no clock edge in between
    @(negedge clk);
    fn_sel = 2'd0; opnd_x = 32'd40; opnd_y = 32'd2;
    #1;
    check("R1 follows add", longint'(result), 42);
    opnd_y = 32'd3;
    #1;
    check("R1 follows y change", longint'(result), 43);

    // R12: 8-bit instance wraps and signs at bit 7
    fn8 = 2'd0; x8 = 8'hFF; y8 = 8'h01;
    #1;
    check("R12 w8 wrap result", longint'(r8), 0);
    check("R12 w8 carry", longint'(c8), 1);
    check("R12 w8 zero", longint'(z8), 1);
    x8 = 8'h7F; y8 = 8'h01;
    #1;
    check("R12 w8 overflow", longint'(o8), 1);
    check("R12 w8 no carry", longint'(c8), 0);
    fn8 = 2'd1; x8 = 8'h80; y8 = 8'h01;
    #1;
    check("R12 w8 sub overflow", longint'(o8), 1);
    check("R12 w8 sub result", longint'(r8), 8'h7F);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule